// File: doc/BRIEF.md
# Dual-path CPU clock selector

This block builds the processor core clock from four level inputs: a crystal clock, two fixed fractions of a high-speed reference (half and third) and a PLL clock. All of them are sampled by a fast system clock `clk_i`. One 32-bit control word sets up two identical low-frequency paths. Each path has a source selector, a 6-bit divider and a bypass of that divider. A final stage picks one of the two paths, or the PLL over both of them.

The two paths are redundant on purpose. Software reprograms the path that is idle and then flips the path bit, so the live clock never passes through a half-configured divider. Every change of the driving source goes through a glitch-free handover. The old source first finishes its high phase. The output then stays low for a synchronisation interval. The new source is only let through once it has been seen low. The block also reports the effective divide ratio of whichever source is driving the output.

Top module: `cpu_clk_sel`

## Requirements
- R1: Control bit 11 set selects the PLL input, whatever bit 10 and the path fields hold. The output then has the PLL period and `ratio_o` reads 1.
- R2: With bit 11 clear, control bit 10 set selects path 1 and bit 10 clear selects path 0.
- R3: Path 0 takes its source code from bits 1:0, its bypass-off flag from bit 2 and its count from bits 9:4. Path 1 uses bits 17:16, 18 and 25:20 for the same roles.
- R4: Source code 0 picks the crystal, 1 the half-rate clock and 2 the third-rate clock. Code 3 has no source, and a path with code 3 drives a constant low.
- R5: When the bypass-off flag is clear, or the count is 0, the ratio is 1. The path output then has the source's period and high time.
- R6: When the bypass-off flag is set and the count n is at least 1, the output period is (n+1) source periods. The high time is ceil((n+1)/2) source periods, which is within one source period of 50 percent.
- R7: A change of the driving source never truncates a phase. The old source leaves only when it is low. The output is held low for at least 2 sampling cycles. The new source enters only after it has been sampled low. No high phase shorter than the shortest source high phase appears.
- R8: A count field is taken only in a cycle where bit 26 is set, or in the cycle right after bit 26 was set. A count change at any other time is ignored.
- R9: A taken count loads at once into a path that is not driving the output. In the driving path it loads only at that divider's next terminal count.
- R10: During reset and right after it, the output is low, path 0 drives, the active counts are 0 and `ratio_o` reads 1.
- R11: `ratio_o` gives the effective ratio of the path currently driving the output (1..64), or 1 while the PLL drives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock, faster than every source |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 32 | Control word |
| xtal_i | input | 1 | Crystal clock level |
| fdiv2_i | input | 1 | Half-rate fixed clock level |
| fdiv3_i | input | 1 | Third-rate fixed clock level |
| pll_i | input | 1 | PLL clock level |
| clk_o | output | 1 | Selected, divided core clock |
| ratio_o | output | 7 | Effective divide ratio of the driving source |

## Verification
Each source code is run in bypass. Because the three sources have distinct periods (10, 4 and 6 cycles), a wrong premux decode shows up as a wrong period. Divided runs use even and odd ratios and the extreme count 63, and check both period and high time. This separates a wrong terminal count from a wrong duty split. The PLL is selected with bit 10 at each value, which shows that the override ignores the path bit. Random programming of the idle path followed by a switch mixes all fields. A final run toggles the path bit at random instants between a slow divided path and a fast bypassed one while the shortest high and low phases are recorded, which exposes any runt pulse.

// File: rtl/cksel_pkg.sv
package cksel_pkg;
  localparam int CTRL_W      = 32;
  localparam int CNT_W       = 6;
  localparam int RAT_W       = CNT_W + 1;
  localparam int SRC_W       = 2;
  localparam int BIT_PLL     = 11;
  localparam int BIT_PATH    = 10;
  localparam int BIT_DYN     = 26;
  localparam int SRC_LSB     = 0;
  localparam int POST_BIT    = 2;
  localparam int CNT_LSB     = 4;
  localparam int PATH_STRIDE = 16;
  localparam int NUM_PATHS   = 2;

  typedef enum logic [1:0] {
    SEL_P0  = 2'd0,
    SEL_P1  = 2'd1,
    SEL_PLL = 2'd2
  } drv_e;

  typedef enum logic [1:0] {
    SW_RUN  = 2'd0,
    SW_SYNC = 2'd1,
    SW_ARM  = 2'd2
  } sw_e;
endpackage

// File: rtl/cksel_path.sv
module cksel_path #(
  parameter int CNT_W = 6,
  localparam int RAT_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       src_sel_i,
  input  logic             post_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_take_i,
  input  logic             selected_i,
  input  logic             xtal_i,
  input  logic             fdiv2_i,
  input  logic             fdiv3_i,
  output logic             clk_o,
  output logic [RAT_W-1:0] ratio_o
);
  logic             src, src_q, rise, tc, wrap, byp, div_q;
  logic [CNT_W-1:0] pend_q, act_q, pos_q, pos_nxt;
  logic [RAT_W-1:0] rat, half;

  always_comb begin
    case (src_sel_i)
      2'd0:    src = xtal_i;
      2'd1:    src = fdiv2_i;
      2'd2:    src = fdiv3_i;
      default: src = 1'b0;
    endcase
  end

  assign rise    = src & ~src_q;
  assign tc      = pos_q >= act_q;
  assign wrap    = rise & tc;
  assign pos_nxt = tc ? '0 : pos_q + 1'b1;
  assign rat     = {1'b0, act_q} + 1'b1;
  assign half    = (rat + 1'b1) >> 1;
  assign byp     = ~post_en_i | (act_q == '0);

  // pending count: captured from the control word when the take strobe allows
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else if (cnt_take_i) pend_q <= cnt_i;
  end

  // active count: free to change when idle, otherwise only at wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else if (!selected_i || wrap) act_q <= pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= 1'b0;
      pos_q <= '0;
      div_q <= 1'b0;
    end else begin
      src_q <= src;
      if (rise) begin
        pos_q <= pos_nxt;
        div_q <= ({1'b0, pos_nxt} < half);
      end
    end
  end

  assign clk_o   = (src_sel_i == 2'd3) ? 1'b0 : (byp ? src_q : div_q);
  assign ratio_o = byp ? RAT_W'(1) : rat;

  AST_DIV_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> $stable(div_q)); // R6

  AST_SEL_COUNT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (selected_i && !wrap) |=> $stable(act_q)); // R9
endmodule

// File: rtl/cksel_switch.sv
module cksel_switch
  import cksel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int SC_W = $clog2(SYNC_STAGES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  drv_e       req_i,
  input  logic [2:0] src_i,
  output drv_e       cur_o,
  output logic       clk_o
);
  sw_e             st_q;
  drv_e            cur_q, tgt_q;
  logic [SC_W-1:0] sc_q;
  logic            clk_q, cur_lvl, tgt_lvl;

  function automatic logic pick(logic [2:0] v, drv_e s);
    case (s)
      SEL_P0:  return v[0];
      SEL_P1:  return v[1];
      default: return v[2];
    endcase
  endfunction

  assign cur_lvl = pick(src_i, cur_q);
  assign tgt_lvl = pick(src_i, tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SW_RUN;
      cur_q <= SEL_P0;
      tgt_q <= SEL_P0;
      sc_q  <= '0;
      clk_q <= 1'b0;
    end else begin
      clk_q <= (st_q == SW_RUN) & cur_lvl;
      case (st_q)
        SW_RUN: begin
          // leave only while the old source is low
          if (req_i != cur_q && !cur_lvl) begin
            st_q  <= SW_SYNC;
            tgt_q <= req_i;
            sc_q  <= '0;
          end
        end
        SW_SYNC: begin
          if (sc_q == SC_W'(SYNC_STAGES - 1)) st_q <= SW_ARM;
          else sc_q <= sc_q + 1'b1;
        end
        SW_ARM: begin
          // enter only after the new source was seen low
          if (!tgt_lvl) begin
            st_q  <= SW_RUN;
            cur_q <= tgt_q;
          end
        end
        default: st_q <= SW_RUN;
      endcase
    end
  end

  assign cur_o = cur_q;
  assign clk_o = clk_q;

  AST_GATED_DURING_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != SW_RUN) |=> !clk_q); // R7

  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SW_RUN && cur_lvl) |=> (st_q == SW_RUN && cur_q == $past(cur_q))); // R7
endmodule

// File: rtl/cpu_clk_sel.sv
module cpu_clk_sel
  import cksel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              xtal_i,
  input  logic              fdiv2_i,
  input  logic              fdiv3_i,
  input  logic              pll_i,
  output logic              clk_o,
  output logic [RAT_W-1:0]  ratio_o
);
  logic             dyn_q, take, pll_q, ctrl_unused;
  drv_e             req, cur;
  logic [NUM_PATHS-1:0] path_clk;
  logic [RAT_W-1:0] path_rat [NUM_PATHS];

  assign ctrl_unused = ^{ctrl_i[31:27], ctrl_i[19], ctrl_i[15:12], ctrl_i[3]};

  // take window covers the strobe cycle and the one after it
  assign take = ctrl_i[BIT_DYN] | dyn_q;

  always_comb begin
    if (ctrl_i[BIT_PLL])       req = SEL_PLL;
    else if (ctrl_i[BIT_PATH]) req = SEL_P1;
    else                       req = SEL_P0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dyn_q <= 1'b0;
      pll_q <= 1'b0;
    end else begin
      dyn_q <= ctrl_i[BIT_DYN];
      pll_q <= pll_i;
    end
  end

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    localparam int BASE = g * PATH_STRIDE;
    cksel_path #(.CNT_W(CNT_W)) u_path (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_sel_i  (ctrl_i[BASE+SRC_LSB +: SRC_W]),
      .post_en_i  (ctrl_i[BASE+POST_BIT]),
      .cnt_i      (ctrl_i[BASE+CNT_LSB +: CNT_W]),
      .cnt_take_i (take),
      .selected_i (cur == drv_e'(g)),
      .xtal_i     (xtal_i),
      .fdiv2_i    (fdiv2_i),
      .fdiv3_i    (fdiv3_i),
      .clk_o      (path_clk[g]),
      .ratio_o    (path_rat[g])
    );
  end

  cksel_switch #(.SYNC_STAGES(SYNC_STAGES)) u_switch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .src_i  ({pll_q, path_clk}),
    .cur_o  (cur),
    .clk_o  (clk_o)
  );

  always_comb begin
    case (cur)
      SEL_P0:  ratio_o = path_rat[0];
      SEL_P1:  ratio_o = path_rat[1];
      default: ratio_o = RAT_W'(1);
    endcase
  end
endmodule

// File: tb/tb_cpu_clk_sel.sv
`timescale 1ns/1ps
module tb_cpu_clk_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl = '0;
  logic        xtal = 1'b0, fdiv2 = 1'b0, fdiv3 = 1'b0, pll = 1'b0;
  logic        clk_o;
  logic [6:0]  ratio_o;

  int n_chk = 0, n_bad = 0;

  cpu_clk_sel dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl),
    .xtal_i(xtal), .fdiv2_i(fdiv2), .fdiv3_i(fdiv3), .pll_i(pll),
    .clk_o(clk_o), .ratio_o(ratio_o)
  );

  always #5 clk = ~clk;

  // source generators: half periods 5, 2, 3, 1 sampling cycles
  int cx = 0, c2 = 0, c3 = 0;
  always @(negedge clk) begin
    if (cx == 4) begin cx = 0; xtal = ~xtal; end else cx++;
    if (c2 == 1) begin c2 = 0; fdiv2 = ~fdiv2; end else c2++;
    if (c3 == 2) begin c3 = 0; fdiv3 = ~fdiv3; end else c3++;
    pll = ~pll;
  end

  // output monitor
  logic prev_o = 1'b0;
  int since_rise = 0, run_len = 0, last_period = 0, last_high = 0, rises = 0;
  int min_high = 1000000, min_low = 1000000;
  bit skip = 1'b1;
  always @(negedge clk) begin
    since_rise++;
    run_len++;
    if (clk_o !== prev_o) begin
      if (prev_o) last_high = run_len;
      if (!skip) begin
        if (prev_o) begin if (run_len < min_high) min_high = run_len; end
        else if (run_len < min_low) min_low = run_len;
      end
      skip = 1'b0;
      if (clk_o) begin last_period = since_rise; since_rise = 0; rises++; end
      run_len = 0;
      prev_o = clk_o;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rises(int n);
    int start;
    start = rises;
    while (rises < start + n) @(negedge clk);
  endtask

  task automatic measure(output int per, output int hi);
    wait_rises(4);
    per = last_period;
    hi  = last_high;
  endtask

  function automatic int src_period(int code);
    case (code)
      0: return 10;
      1: return 4;
      2: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_ratio(int pm, int cnt);
    return (pm == 0 || cnt == 0) ? 1 : cnt + 1;
  endfunction

  function automatic int exp_high(int code, int r);
    return (r == 1) ? src_period(code) / 2 : ((r + 1) / 2) * src_period(code);
  endfunction

  task automatic prog_path(int p, int src, int pm, int cnt, bit pulse);
    int b;
    b = p * 16;
    ctrl[b +: 2]   = src[1:0];
    ctrl[b + 2]    = pm[0];
    ctrl[b + 4 +: 6] = cnt[5:0];
    if (pulse) ctrl[26] = 1'b1;
    tick(1);
    ctrl[26] = 1'b0;
    tick(1);
  endtask

  task automatic pick_src(int s);
    if (s == 2) ctrl[11] = 1'b1;
    else begin ctrl[11] = 1'b0; ctrl[10] = s[0]; end
  endtask

  task automatic run_case(int p, int src, int pm, int cnt, string tag);
    int per, hi, r;
    prog_path(p, src, pm, cnt, 1'b1);
    pick_src(p);
    r = exp_ratio(pm, cnt);
    measure(per, hi);
    check(per == src_period(src) * r, {tag, " period"}, per, src_period(src) * r);
    check(hi == exp_high(src, r), {tag, " high"}, hi, exp_high(src, r));
    check(int'(ratio_o) == r, {tag, " R11 ratio"}, int'(ratio_o), r);
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int per, hi, cur_p, idle, seed;
    seed = $urandom(32'h1f3a);
    tick(3);
    // R10: reset state
    check(clk_o == 1'b0, "R10 clk_o in reset", clk_o, 0);
    check(ratio_o == 7'd1, "R10 ratio in reset", ratio_o, 1);
    rst_n = 1'b1;
    tick(1);
    check(ratio_o == 7'd1, "R10 ratio after reset", ratio_o, 1);
    measure(per, hi);
    check(per == 10, "R10 path0 crystal after reset", per, 10);

    // R4 R5: every source code in bypass, count set but bypass on
    cur_p = 0;
    for (int s = 0; s < 3; s++) begin
      idle = 1 - cur_p;
      run_case(idle, s, 0, 7, "R4 R5 bypass");
      cur_p = idle;
    end

    // R4: code 3 holds low
    idle = 1 - cur_p;
    prog_path(idle, 3, 1, 2, 1'b1);
    pick_src(idle);
    cur_p = idle;
    tick(60);
    begin
      int r0;
      bit seen_high;
      r0 = rises;
      seen_high = 1'b0;
      for (int k = 0; k < 200; k++) begin
        tick(1);
        if (clk_o) seen_high = 1'b1;
      end
      check(!seen_high && rises == r0, "R4 code 3 held low", int'(seen_high), 0);
    end

    // R3 R2 R6: field placement on each path, odd and even ratios
    run_case(1, 2, 1, 4, "R3 R2 R6 path1");
    run_case(0, 1, 1, 2, "R3 R2 R6 path0");
    run_case(1, 1, 1, 63, "R6 count 63");
    cur_p = 1;

    // R1: PLL override with both values of bit 10
    ctrl[10] = 1'b0;
    pick_src(2);
    measure(per, hi);
    check(per == 2 && hi == 1, "R1 pll bit10=0 period", per, 2);
    check(ratio_o == 7'd1, "R1 R11 pll ratio", ratio_o, 1);
    ctrl[10] = 1'b1;
    measure(per, hi);
    check(per == 2, "R1 pll bit10=1 period", per, 2);
    pick_src(cur_p);
    wait_rises(3);

    // random mix on the idle path, then switch
    for (int it = 0; it < 16; it++) begin
      int s, pm, c;
      idle = 1 - cur_p;
      s  = int'($urandom_range(2, 0));
      pm = int'($urandom_range(1, 0));
      c  = int'($urandom_range(15, 0));
      run_case(idle, s, pm, c, "R6 R2 random");
      cur_p = idle;
    end

    // R9: driving path loads only at terminal count
    idle = 1 - cur_p;
    prog_path(idle, 0, 1, 39, 1'b1);
    pick_src(idle);
    cur_p = idle;
    wait_rises(2);
    prog_path(cur_p, 0, 1, 1, 1'b1);
    tick(2);
    check(ratio_o == 7'd40, "R9 driving path holds old count", ratio_o, 40);
    tick(450);
    check(ratio_o == 7'd2, "R9 driving path loads at wrap", ratio_o, 2);

    // R9: idle path loads at once
    idle = 1 - cur_p;
    prog_path(idle, 0, 1, 62, 1'b1);
    tick(5);
    prog_path(idle, 0, 1, 3, 1'b1);
    pick_src(idle);
    cur_p = idle;
    tick(60);
    check(ratio_o == 7'd4, "R9 idle path loads at once", ratio_o, 4);

    // R8: count change without strobe ignored (idle path still holds 1)
    idle = 1 - cur_p;
    prog_path(idle, 0, 1, 9, 1'b0);
    pick_src(idle);
    cur_p = idle;
    tick(60);
    check(ratio_o == 7'd2, "R8 count without strobe ignored", ratio_o, 2);

    // R8: field written in the cycle after the strobe is taken
    idle = 1 - cur_p;
    ctrl[26] = 1'b1;
    tick(1);
    ctrl[26] = 1'b0;
    ctrl[idle*16 + 4 +: 6] = 6'd5;
    tick(2);
    pick_src(idle);
    cur_p = idle;
    tick(80);
    check(ratio_o == 7'd6, "R8 count taken after strobe", ratio_o, 6);

    // R7: random path flips between slow divided and fast bypassed paths
    prog_path(0, 0, 1, 1, 1'b1);
    prog_path(1, 2, 0, 0, 1'b1);
    ctrl[11] = 1'b0;
    wait_rises(3);
    min_high = 1000000;
    min_low  = 1000000;
    skip = 1'b1;
    begin
      int r0;
      r0 = rises;
      for (int k = 0; k < 40; k++) begin
        ctrl[10] = ~ctrl[10];
        tick(5 + int'($urandom_range(50, 0)));
      end
      check(rises > r0 + 20, "R7 output keeps running", rises - r0, 21);
    end
    check(min_high >= 3, "R7 no runt high", min_high, 3);
    check(min_low >= 2, "R7 no runt low", min_low, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule